// File: doc/BRIEF.md
# Identifier Acceptance Filter with Per-Bit Masks

This block decides whether the identifier of a received frame is of interest to the host. It holds four programmable pairs of registers. Each pair has a match pattern (the filter) and a relevance mask. A simple write port loads them. When the receive path presents an 11-bit standard identifier with a one-cycle strobe, the block compares that identifier against every pair in parallel. One clock later it reports a result pulse, an accept flag, and the number of the lowest-numbered pair that matched.

In each pair the mask decides which bit positions count. A position whose mask bit is 0 is a don't-care, whatever the filter and identifier hold there. A position whose mask bit is 1 must carry the same value in the identifier as in the filter. One pair can therefore admit a single identifier, when every mask bit is set, or a whole family of identifiers, when some mask bits are cleared. The accept flag and the index are held from one strobe to the next, so the host can read them at leisure.

Top module: `id_accept_filter`

## Requirements
- R1: After reset, res_valid, res_accept and res_index are 0. Every pair then holds filter 0x000 and mask 0x7FF, so the only identifier accepted is 0x000, and it reports index 0.
- R2: For each bit position where a pair's mask bit is 1, the pair matches only if the identifier bit equals the filter bit.
- R3: For each bit position where a pair's mask bit is 0, the identifier and filter bits are ignored. A pair whose mask is 0x000 matches every identifier.
- R4: A pair with mask 0x7F5 and filter 0x35E matches exactly the four identifiers 0x354, 0x356, 0x35C and 0x35E.
- R5: A pair with an all-ones mask matches exactly one identifier. With filter 0x088, mask 0x7FF admits only 0x088. Mask 0x7FE admits 0x088 and 0x089. Mask 0x7FD admits 0x088 and 0x08A.
- R6: res_valid is high for exactly one cycle, in the cycle after a cycle with id_valid high. res_accept is then the OR of the four pair matches for that identifier.
- R7: When several pairs match, res_index is the lowest matching pair number. When no pair matches, res_index is 0.
- R8: Between strobes, res_accept and res_index keep their values, whatever id_in does.
- R9: The write port stores cfg_data into pair cfg_idx when cfg_we is high. cfg_sel 0 selects the filter and cfg_sel 1 selects the mask. A write in the same cycle as a strobe does not affect that strobe's result, and it takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 = filter register, 1 = mask register |
| cfg_idx | input | 2 | Pair number to write |
| cfg_data | input | 11 | Value to store |
| id_valid | input | 1 | Identifier strobe |
| id_in | input | 11 | Received standard identifier |
| res_valid | output | 1 | One-cycle pulse after each strobe |
| res_accept | output | 1 | Identifier matched at least one pair |
| res_index | output | 2 | Lowest matching pair number (0 if none) |

## Verification
The main function is swept over all 2048 identifiers under four configurations. The reset configuration tells exact matching apart from partial matching. A configuration with family masks checks that the matched sets have the documented sizes and members. A configuration with all masks cleared separates don't-care handling from compare handling. A configuration with overlapping families separates lowest-index priority from any other ordering. Directed strobes then probe result holding between strobes and a write that coincides with a strobe, which separates old register contents from new ones.

// File: rtl/id_filt_pkg.sv
package id_filt_pkg;

  typedef enum logic {
    SEL_FILTER = 1'b0,
    SEL_MASK   = 1'b1
  } cfg_sel_e;

  // one bit position: relevant only when the mask bit is set
  function automatic logic bit_ok(input logic id_b, input logic flt_b, input logic msk_b);
    return (!msk_b) || (id_b == flt_b);
  endfunction

endpackage

// File: rtl/id_filt_regs.sv
module id_filt_regs #(
  parameter int ID_W      = 11,
  parameter int NUM_PAIRS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic                            cfg_sel,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic [ID_W-1:0]                 cfg_data,
  output logic [NUM_PAIRS-1:0][ID_W-1:0]  filt_q,
  output logic [NUM_PAIRS-1:0][ID_W-1:0]  mask_q
);
  import id_filt_pkg::*;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic sel_here;
    assign sel_here = cfg_we && (cfg_idx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filt_q[p] <= '0;
        mask_q[p] <= '1;
      end else if (sel_here) begin
        if (cfg_sel == SEL_MASK) mask_q[p] <= cfg_data;
        else                     filt_q[p] <= cfg_data;
      end
    end
  end

endmodule

// File: rtl/id_filt_cmp.sv
module id_filt_cmp #(
  parameter int ID_W      = 11,
  parameter int NUM_PAIRS = 4
) (
  input  logic [ID_W-1:0]                 id_in,
  input  logic [NUM_PAIRS-1:0][ID_W-1:0]  filt_q,
  input  logic [NUM_PAIRS-1:0][ID_W-1:0]  mask_q,
  output logic [NUM_PAIRS-1:0]            hit_vec
);
  import id_filt_pkg::*;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [ID_W-1:0] bit_pass;
    for (genvar b = 0; b < ID_W; b++) begin : g_bit
      assign bit_pass[b] = bit_ok(id_in[b], filt_q[p][b], mask_q[p][b]);
    end
    assign hit_vec[p] = &bit_pass;
  end

endmodule

// File: rtl/id_filt_prio.sv
module id_filt_prio #(
  parameter int NUM_PAIRS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_PAIRS-1:0] hit_vec,
  output logic                 any_hit,
  output logic [IDX_W-1:0]     low_idx
);

  always_comb begin
    any_hit = |hit_vec;
    low_idx = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
      if (hit_vec[i]) low_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter #(
  parameter int ID_W      = 11,
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [ID_W-1:0]  cfg_data,
  input  logic             id_valid,
  input  logic [ID_W-1:0]  id_in,
  output logic             res_valid,
  output logic             res_accept,
  output logic [IDX_W-1:0] res_index
);

  // named internal events, observed by the bound checker
  logic [NUM_PAIRS-1:0][ID_W-1:0] filt_q;
  logic [NUM_PAIRS-1:0][ID_W-1:0] mask_q;
  logic [NUM_PAIRS-1:0]           hit_vec;
  logic                           any_hit;
  logic [IDX_W-1:0]               low_idx;

  id_filt_regs #(.ID_W(ID_W), .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data),
    .filt_q   (filt_q),
    .mask_q   (mask_q)
  );

  id_filt_cmp #(.ID_W(ID_W), .NUM_PAIRS(NUM_PAIRS)) u_cmp (
    .id_in   (id_in),
    .filt_q  (filt_q),
    .mask_q  (mask_q),
    .hit_vec (hit_vec)
  );

  id_filt_prio #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_prio (
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .low_idx (low_idx)
  );

  // the compare uses register contents from before this edge, so a
  // simultaneous write only counts from the next strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid <= id_valid;
      if (id_valid) begin
        res_accept <= any_hit;
        res_index  <= low_idx;
      end
    end
  end

endmodule

// File: rtl/id_filt_chk.sv
module id_filt_chk #(
  parameter int NUM_PAIRS = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 id_valid,
  input logic [NUM_PAIRS-1:0] hit_vec,
  input logic                 res_valid,
  input logic                 res_accept,
  input logic [IDX_W-1:0]     res_index
);

  logic [NUM_PAIRS-1:0] hit_d;
  logic                 idx_hit;
  logic                 none_below;

  always_ff @(posedge clk) begin
    if (!rst_n) hit_d <= '0;
    else        hit_d <= hit_vec;
  end

  always_comb begin
    idx_hit    = 1'b0;
    none_below = 1'b1;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (IDX_W'(i) == res_index) idx_hit = hit_d[i];
      if (IDX_W'(i) < res_index && hit_d[i]) none_below = 1'b0;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> res_valid); // R6
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !res_valid); // R6
  AST_ACCEPT_OR: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> (res_accept == (|hit_d))); // R6
  AST_INDEX_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && (|hit_vec)) |=> idx_hit); // R7
  AST_INDEX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> none_below); // R7
  AST_NO_MATCH_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !(|hit_vec)) |=> (res_index == '0)); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> ($stable(res_accept) && $stable(res_index))); // R8

endmodule

bind id_accept_filter id_filt_chk #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid   (id_valid),
  .hit_vec    (hit_vec),
  .res_valid  (res_valid),
  .res_accept (res_accept),
  .res_index  (res_index)
);

// File: tb/tb_id_accept_filter.sv
module tb_id_accept_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [10:0] cfg_data = '0;
  logic        id_valid = 1'b0;
  logic [10:0] id_in = '0;
  logic        res_valid;
  logic        res_accept;
  logic [1:0]  res_index;

  int checks = 0;
  int fails  = 0;

  // bench-side copy of the programmed pairs
  logic [10:0] fm [4];
  logic [10:0] mm [4];
  int          per_idx [4];
  int          acc_total;
  logic        seen_fam [4];

  always #10 clk = ~clk;  // 50 MHz

  id_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .id_valid(id_valid),
    .id_in(id_in), .res_valid(res_valid), .res_accept(res_accept),
    .res_index(res_index)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected result by walking the bits one at a time
  function automatic void predict(input int id, output int acc, output int idx);
    acc = 0;
    idx = 0;
    for (int p = 3; p >= 0; p--) begin
      int bad = 0;
      for (int b = 0; b < 11; b++)
        if (mm[p][b] && (((id >> b) & 1) != int'(fm[p][b]))) bad = 1;
      if (bad == 0) begin
        acc = 1;
        idx = p;
      end
    end
  endfunction

  task automatic wr(input int sel, input int p, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[0]; cfg_idx = p[1:0]; cfg_data = val[10:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 1) mm[p] = val[10:0];
    else          fm[p] = val[10:0];
  endtask

  task automatic set_pair(input int p, input int f, input int m);
    wr(0, p, f);
    wr(1, p, m);
  endtask

  // strobe one identifier; on return the registered result is visible
  task automatic strobe(input int id);
    @(negedge clk);
    id_in = id[10:0]; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    int acc, idx;
    acc_total = 0;
    for (int p = 0; p < 4; p++) per_idx[p] = 0;
    for (int id = 0; id < 2048; id++) begin
      strobe(id);
      predict(id, acc, idx);
      chk(req, {res_valid, res_accept, 2'b00, res_index}, {1'b1, acc[0], 2'b00, idx[1:0]});
      if (res_accept) begin
        acc_total++;
        per_idx[res_index]++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin fm[p] = 11'h000; mm[p] = 11'h7FF; end
    repeat (3) @(negedge clk);
    chk("R1 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset outputs", {res_valid, res_accept, res_index}, 0);

    // reset configuration: only 0x000 passes
    sweep("R1 R2 reset sweep");
    chk("R1 accepted count", acc_total, 1);

    // family masks and exact masks
    set_pair(0, 11'h35E, 11'h7F5);
    set_pair(1, 11'h088, 11'h7FF);
    set_pair(2, 11'h088, 11'h7FE);
    set_pair(3, 11'h088, 11'h7FD);
    sweep("R2 R4 R5 R7 family sweep");
    chk("R4 pair0 family size", per_idx[0], 4);
    chk("R5 exact pair1 count", per_idx[1], 1);
    chk("R5 pair2 only 0x089", per_idx[2], 1);
    chk("R5 pair3 only 0x08A", per_idx[3], 1);
    for (int k = 0; k < 4; k++) begin
      int fam [4] = '{11'h354, 11'h356, 11'h35C, 11'h35E};
      strobe(fam[k]);
      chk("R4 family member", {res_accept, res_index}, {1'b1, 2'd0});
    end
    strobe(11'h088);
    chk("R7 0x088 lowest of three", {res_accept, res_index}, {1'b1, 2'd1});
    strobe(11'h089);
    chk("R5 0x089 via pair2", {res_accept, res_index}, {1'b1, 2'd2});
    strobe(11'h08A);
    chk("R5 0x08A via pair3", {res_accept, res_index}, {1'b1, 2'd3});
    strobe(11'h08B);
    chk("R7 no match index 0", {res_accept, res_index}, 0);

    // every mask cleared: all identifiers pass on pair 0
    for (int p = 0; p < 4; p++) wr(1, p, 11'h000);
    sweep("R3 all-dont-care sweep");
    chk("R3 accepted count", acc_total, 2048);
    chk("R7 all on pair0", per_idx[0], 2048);

    // overlapping families for priority
    set_pair(0, 11'h700, 11'h700);
    set_pair(1, 11'h000, 11'h001);
    set_pair(2, 11'h2AA, 11'h7F0);
    set_pair(3, 11'h7FF, 11'h7FF);
    sweep("R6 R7 overlap sweep");
    chk("R7 pair0 count", per_idx[0], 256);
    chk("R7 pair1 count", per_idx[1], 896);
    chk("R7 pair2 count", per_idx[2], 8);
    chk("R7 pair3 count", per_idx[3], 0);

    // hold between strobes
    strobe(11'h2A5);
    chk("R8 strobe result", {res_accept, res_index}, {1'b1, 2'd2});
    for (int k = 0; k < 4; k++) begin
      id_in = 11'(k * 3);
      @(negedge clk);
      chk("R6 no pulse without strobe", res_valid, 0);
      chk("R8 held result", {res_accept, res_index}, {1'b1, 2'd2});
    end

    // write colliding with a strobe
    set_pair(0, 11'h123, 11'h7FF);
    set_pair(1, 11'h7FF, 11'h7FF);
    set_pair(2, 11'h7FF, 11'h7FF);
    set_pair(3, 11'h7FF, 11'h7FF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 2'd0; cfg_data = 11'h456;
    id_in = 11'h123; id_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; id_valid = 1'b0;
    chk("R9 same-cycle write uses old filter", {res_valid, res_accept, res_index}, {1'b1, 1'b1, 2'd0});
    fm[0] = 11'h456;
    strobe(11'h123);
    chk("R9 old value gone", res_accept, 0);
    strobe(11'h456);
    chk("R9 new value live", {res_accept, res_index}, {1'b1, 2'd0});
    wr(1, 2, 11'h000);
    strobe(11'h001);
    chk("R9 mask write to pair2", {res_accept, res_index}, {1'b1, 2'd2});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule